// File: doc/BRIEF.md
# MDIO Management Slave Port

This block is the PHY-side end of a two-wire management bus. A station supplies a management clock (MDC) and shares one bidirectional data line (MDIO). The line appears here as three signals: the sampled input, the value to drive, and a drive enable that an I/O pad combines with an external pull-up. The block decodes read and write frames addressed to it and serves them from a bank of 32 sixteen-bit storage words held inside the block.

MDC and the sampled MDIO input are assumed to be already synchronous to the fast system clock `clk`. The block finds MDC rising edges by comparing MDC with its value one `clk` cycle earlier. Every frame decision is taken on such an edge, so MDC may stop at any point and the port simply waits. The bus address of the port is copied from strap inputs while reset is held low. The first MDC rising edge after reset is released is discarded.

Top module: `mdio_slave`

## Requirements
- R1: MDIO is sampled only on MDC rising edges. Any number of leading 1 bits, from none to 32 or more, is skipped. A frame begins at the bit pair 0 then 1. Frames may follow one another with no idle bit in between.
- R2: After the start pair, the frame holds a 2-bit opcode, a 5-bit bus address, a 5-bit register index, 2 turnaround bits and 16 data bits, each field MSB first. Opcode 01 with a matching address stores the data bits into the indexed word. The stored value is visible to the next frame. The drive enable stays low for the whole write frame.
- R3: Opcode 10 with a matching address is a read. The drive enable stays low while the first turnaround bit is on the line. It rises just after the MDC edge that samples that bit, and the driven value is 0 for the second turnaround bit. After each of the next 16 edges, the next data bit is driven, MSB first. The enable falls just after the edge that samples the last data bit.
- R4: The bus address is copied from the strap inputs while reset is low and is zero-extended to 5 bits when ADDR_W is 4. Strap changes after reset have no effect.
- R5: A frame whose address field differs from the latched address is followed through its full 30 bits after the start pair. It writes nothing and never raises the drive enable.
- R6: A frame with opcode 00 or 11 is handled the same way as in R5: it is followed to its end and has no effect.
- R7: The first MDC rising edge after reset is released is ignored. A 0 sampled on that edge does not count as a start bit.
- R8: While reset is low, and right after it, the drive enable and driven value are 0 and every storage word reads back as 0000.
- R9: If MDC stays low for any length of time in the middle of a frame, the frame state does not change. Decoding resumes correctly when MDC restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; MDC and MDIO input are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset; straps are copied while low |
| strap_addr | input | ADDR_W | Bus address strap pins |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value to drive onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO (1 = drive) |

## Verification
Two functions can land on the same MDC edge: the reset blanking of R7 and the first bit of a frame. The bench provokes this by releasing reset and starting a write frame with its start 0 on the very first rising edge. The port must then realign on a later 0-then-1 pair, take the misaligned header as a foreign frame, and leave the target word at 0. This is judged edge by edge against a behavioural bit-queue model, and again by an independent read-back once the line has idled. A second overlap is covered by frames sent with no idle bits between them: the edge that commits a write is immediately followed by the start of a read of the same word.

// File: rtl/mdio_pkg.sv
// Package mdio_pkg
// Shared constants and the frame-state type of the management slave port.
// Assumes the standard frame layout: 2-bit opcode, 5-bit address fields,
// two turnaround bits and a 16-bit data word.
package mdio_pkg;
    localparam int FIELD_W  = 5;                  // width of address and index fields
    localparam int DATA_W   = 16;                 // width of one storage word
    localparam int OP_W     = 2;                  // opcode width
    localparam int HDR_BITS = OP_W + 2 * FIELD_W; // opcode + bus address + index
    localparam int NWORDS   = 2 ** FIELD_W;       // directly addressed words
    localparam int CNT_W    = 5;                  // bit counter width

    localparam logic [OP_W-1:0] OP_RD = 2'b10;
    localparam logic [OP_W-1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for the first 0 of the start pair
        S_START,  // waiting for the 1 that completes the start pair
        S_HDR,    // shifting in opcode, bus address and index
        S_TA,     // two turnaround bit times
        S_DATA    // sixteen data bit times
    } frame_state_e;
endpackage

// File: rtl/mdio_edge_gate.sv
// Module mdio_edge_gate
// Finds MDC rising edges in the clk domain and withholds the first one
// after reset is released. Assumes mdc is already synchronous to clk.
module mdio_edge_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    output logic bit_stb,
    output logic armed
);
    logic mdc_q;
    logic rise;

    assign rise    = mdc & ~mdc_q;
    assign bit_stb = rise & armed;

    // Track MDC (also during reset, so a high MDC gives no false edge) and arm after one edge.
    always_ff @(posedge clk) begin
        mdc_q <= mdc;
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (rise) begin
            armed <= 1'b1;
        end
    end

    // R7: the edge that arms the gate is never passed on as a bit strobe
    a_r7_first_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !armed) |-> !bit_stb);
endmodule

// File: rtl/mdio_word_bank.sv
// Module mdio_word_bank
// Generic storage of NW words of DW bits with one registered write port
// and one combinational read port. All words clear on reset.
module mdio_word_bank #(
    parameter int NW = 32,
    parameter int DW = 16,
    localparam int AW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] words [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        // Hold one word; load it when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/mdio_frame_fsm.sv
// Module mdio_frame_fsm
// Walks one management frame per bit strobe: finds the start pair, collects
// the header, decides whether the frame is accepted, then either shifts read
// data out or collects write data. A frame that is not accepted is followed
// to its end without effect. Assumes bit_stb marks a valid MDC rising edge.
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_stb,
    input  logic               din,
    input  logic [FIELD_W-1:0] own_addr,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [FIELD_W-1:0] word_idx,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_data,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe
);
    frame_state_e          state;
    logic [CNT_W-1:0]      cnt;
    logic [HDR_BITS-1:0]   hdr;
    logic [HDR_BITS-1:0]   hdr_nxt;
    logic                  act;
    logic                  is_rd;
    logic [DATA_W-1:0]     shreg;
    logic [DATA_W-1:0]     wdat;
    logic [OP_W-1:0]       op_nxt;
    logic [FIELD_W-1:0]    phy_nxt;

    // Header as it will be after the current bit is shifted in.
    always_comb begin
        hdr_nxt = {hdr[HDR_BITS-2:0], din};
        op_nxt  = hdr_nxt[HDR_BITS-1 -: OP_W];
        phy_nxt = hdr_nxt[2*FIELD_W-1 -: FIELD_W];
    end

    assign word_idx = hdr[FIELD_W-1:0];
    assign wr_data  = wdat;
    assign busy     = (state != S_IDLE);

    // Frame sequencer: one step per accepted MDC rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            hdr     <= '0;
            act     <= 1'b0;
            is_rd   <= 1'b0;
            shreg   <= '0;
            wdat    <= '0;
            wr_en   <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (bit_stb) begin
                unique case (state)
                    S_IDLE: begin
                        if (!din) state <= S_START;
                    end
                    S_START: begin
                        if (din) begin
                            state <= S_HDR;
                            cnt   <= '0;
                            act   <= 1'b0;
                        end
                    end
                    S_HDR: begin
                        hdr <= hdr_nxt;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(HDR_BITS - 1)) begin
                            state <= S_TA;
                            cnt   <= '0;
                            act   <= (phy_nxt == own_addr) &&
                                     ((op_nxt == OP_RD) || (op_nxt == OP_WR));
                            is_rd <= (op_nxt == OP_RD);
                        end
                    end
                    S_TA: begin
                        if (cnt == '0) begin
                            cnt <= 1'b1;
                            if (act && is_rd) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                                shreg   <= rd_data;
                            end
                        end else begin
                            state <= S_DATA;
                            cnt   <= '0;
                            if (act && is_rd) begin
                                mdio_o <= shreg[DATA_W-1];
                                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    S_DATA: begin
                        wdat <= {wdat[DATA_W-2:0], din};
                        cnt  <= cnt + 1'b1;
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            state   <= S_IDLE;
                            cnt     <= '0;
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                            wr_en   <= act && !is_rd;
                        end else if (act && is_rd) begin
                            mdio_o <= shreg[DATA_W-1];
                            shreg  <= {shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R3: the line is driven only inside an accepted read frame
    a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (act && is_rd && (state == S_TA || state == S_DATA)));

    // R3: the first driven bit is the low turnaround bit
    a_r3_ta2_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R2: an accepted write never drives the line
    a_r2_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !is_rd) |-> !mdio_oe);

    // R2: a store request comes only at the end of an accepted write
    a_r2_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == S_IDLE && act && !is_rd));

    // R4 R5 R6: acceptance needs a matching address and a legal opcode
    a_r5_accept_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (state == S_TA || state == S_DATA)) |->
        (hdr[2*FIELD_W-1 -: FIELD_W] == own_addr &&
         (hdr[HDR_BITS-1 -: OP_W] == OP_RD || hdr[HDR_BITS-1 -: OP_W] == OP_WR)));

    // R9: without a bit strobe the sequencer does not move
    a_r9_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(state) && $stable(cnt)));
endmodule

// File: rtl/mdio_slave.sv
// Module mdio_slave
// Top of the management slave port: copies the bus address from straps
// during reset, gates MDC edges, runs the frame sequencer and holds the
// word bank. Assumes mdc and mdio_i are synchronous to clk; ADDR_W is 4 or 5.
module mdio_slave
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [ADDR_W-1:0]  strap_q;
    logic [FIELD_W-1:0] own_addr;
    logic               bit_stb;
    logic               armed;
    logic [FIELD_W-1:0] word_idx;
    logic               wr_en;
    logic [DATA_W-1:0]  wr_data;
    logic [DATA_W-1:0]  rd_data;
    logic               busy;

    // Copy the strap pins while reset is held; keep them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_addr;
    end

    assign own_addr = FIELD_W'(strap_q);

    mdio_edge_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .bit_stb (bit_stb),
        .armed   (armed)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .din      (mdio_i),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .word_idx (word_idx),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_word_bank #(
        .NW (NWORDS),
        .DW (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (word_idx),
        .wr_data (wr_data),
        .rd_idx  (word_idx),
        .rd_data (rd_data)
    );

    // R7: until the first edge has been discarded no frame is in progress
    a_r7_blank_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!busy && !mdio_oe));

    // R4: the latched address never changes outside reset
    a_r4_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(strap_q));
endmodule

// File: tb/mdio_slave_tb.sv
// Bench for mdio_slave: drives MDC/MDIO as a station would, and compares
// the drive enable and driven value after every MDC rising edge with a
// behavioural bit-queue model.
module mdio_slave_tb;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] strap;
    logic              mdc;
    logic              mdio_i;
    logic              mdio_o;
    logic              mdio_oe;

    always #2.5 clk = ~clk;

    mdio_slave #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap),
        .mdc        (mdc),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string cur_req = "R8";

    // behavioural model state
    logic [15:0] mregs [32];
    bit          m_armed;
    int          m_phase;
    int          m_k;
    logic        q[$];
    bit          m_act, m_rd;
    logic [4:0]  m_own, m_idx;
    logic [15:0] m_val;
    logic        exp_oe, exp_out;
    logic [15:0] cap;

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_word(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (mregs[i]) mregs[i] = 16'h0000;
        m_armed = 1'b0; m_phase = 0; m_k = 0; q.delete();
        m_act = 1'b0; m_rd = 1'b0; exp_oe = 1'b0; exp_out = 1'b0;
        m_own = 5'(strap);
    endtask

    // Model of one MDC rising edge, built on a queue of received bits.
    task automatic model_edge(logic b);
        if (!m_armed) begin
            m_armed = 1'b1;
            return;
        end
        if (m_phase == 0) begin
            if (b == 1'b0) m_phase = 1;
        end else if (m_phase == 1) begin
            if (b == 1'b1) begin m_phase = 2; m_k = 0; q.delete(); end
        end else begin
            q.push_back(b);
            m_k++;
            if (m_k == 12) begin
                logic [1:0] op;
                logic [4:0] phy;
                op = {q[0], q[1]};
                for (int i = 0; i < 5; i++) begin
                    phy[4-i]   = q[2+i];
                    m_idx[4-i] = q[7+i];
                end
                m_act = (phy == m_own) && (op == 2'b10 || op == 2'b01);
                m_rd  = (op == 2'b10);
            end else if (m_k == 13) begin
                if (m_act && m_rd) begin
                    exp_oe = 1'b1; exp_out = 1'b0; m_val = mregs[m_idx];
                end
            end else if (m_k >= 14 && m_k <= 29) begin
                if (m_act && m_rd) exp_out = m_val[15-(m_k-14)];
            end else if (m_k == 30) begin
                exp_oe = 1'b0; exp_out = 1'b0;
                if (m_act && !m_rd) begin
                    logic [15:0] w;
                    for (int i = 0; i < 16; i++) w[15-i] = q[14+i];
                    mregs[m_idx] = w;
                end
                m_phase = 0;
            end
        end
    endtask

    // One MDC period of 8 clk cycles; checks the outputs 2 cycles after the rise.
    task automatic send_bit(logic b);
        @(negedge clk) mdio_i = b;
        repeat (3) @(negedge clk);
        mdc = 1'b1;
        model_edge(b);
        repeat (2) @(negedge clk);
        check_bit(cur_req, "drive enable", mdio_oe, exp_oe);
        if (exp_oe) check_bit(cur_req, "driven bit", mdio_o, exp_out);
        if (m_phase == 2 && m_act && m_rd && m_k >= 14 && m_k <= 29)
            cap = {cap[14:0], mdio_o};
        repeat (2) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_frame(int npre, logic [1:0] op, logic [4:0] phy,
                              logic [4:0] idx, logic [15:0] data, int pause_at);
        logic [31:0] bits;
        cap  = 16'h0000;
        bits = {2'b01, op, phy, idx, (op == 2'b01) ? 2'b10 : 2'b11,
                (op == 2'b10) ? 16'hFFFF : data};
        repeat (npre) send_bit(1'b1);
        for (int i = 31; i >= 0; i--) begin
            if (31 - i == pause_at) repeat (60) @(negedge clk);
            send_bit(bits[i]);
        end
    endtask

    task automatic do_reset(logic [ADDR_W-1:0] s);
        rst_n = 1'b0; strap = s; mdc = 1'b0; mdio_i = 1'b1;
        repeat (4) @(negedge clk);
        model_reset();
        check_bit("R8", "drive enable in reset", mdio_oe, 1'b0);
        check_bit("R8", "driven bit in reset", mdio_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset(5'h0B);
        // R8: fresh storage reads zero
        cur_req = "R8";
        send_bit(1'b1); send_bit(1'b1);
        send_frame(0, 2'b10, 5'h0B, 5'd5, 16'h0, -1);
        check_word("R8", "word 5 after reset", cap, 16'h0000);

        // R1 R2: long preamble write, then read with no preamble (R3)
        cur_req = "R2";
        send_frame(32, 2'b01, 5'h0B, 5'd3, 16'hA5C3, -1);
        cur_req = "R3";
        send_frame(0, 2'b10, 5'h0B, 5'd3, 16'h0, -1);
        check_word("R3", "read word 3", cap, 16'hA5C3);

        // R2: highest index, single preamble bit
        cur_req = "R2";
        send_frame(1, 2'b01, 5'h0B, 5'd31, 16'h8001, -1);
        send_frame(2, 2'b10, 5'h0B, 5'd31, 16'h0, -1);
        check_word("R2", "read word 31", cap, 16'h8001);
        send_frame(2, 2'b10, 5'h0B, 5'd0, 16'h0, -1);
        check_word("R2", "word 0 untouched", cap, 16'h0000);

        // R4: strap change after reset has no effect
        cur_req = "R4";
        strap = 5'h14;
        send_frame(1, 2'b10, 5'h0B, 5'd3, 16'h0, -1);
        check_word("R4", "old address still answers", cap, 16'hA5C3);
        send_frame(1, 2'b10, 5'h14, 5'd3, 16'h0, -1);

        // R5: foreign address write and read
        cur_req = "R5";
        send_frame(1, 2'b01, 5'h0A, 5'd3, 16'hFFFF, -1);
        send_frame(1, 2'b10, 5'h0A, 5'd3, 16'h0, -1);
        send_frame(1, 2'b10, 5'h0B, 5'd3, 16'h0, -1);
        check_word("R5", "word 3 after foreign write", cap, 16'hA5C3);

        // R6: illegal opcodes
        cur_req = "R6";
        send_frame(1, 2'b00, 5'h0B, 5'd3, 16'h0000, -1);
        send_frame(1, 2'b11, 5'h0B, 5'd3, 16'h1111, -1);
        send_frame(1, 2'b10, 5'h0B, 5'd3, 16'h0, -1);
        check_word("R6", "word 3 after illegal opcodes", cap, 16'hA5C3);

        // R9: MDC stopped mid-header and mid-data
        cur_req = "R9";
        send_frame(1, 2'b01, 5'h0B, 5'd9, 16'h1234, 10);
        send_frame(1, 2'b10, 5'h0B, 5'd9, 16'h0, 22);
        check_word("R9", "word 9 after paused frames", cap, 16'h1234);

        // R1: back-to-back frames, write then read of the same word
        cur_req = "R1";
        send_frame(0, 2'b01, 5'h0B, 5'd12, 16'hBEEF, -1);
        send_frame(0, 2'b10, 5'h0B, 5'd12, 16'h0, -1);
        check_word("R1", "back-to-back read", cap, 16'hBEEF);

        // R7: frame starts on the first edge after a new reset
        do_reset(5'h12);
        cur_req = "R7";
        send_frame(0, 2'b01, 5'h12, 5'd7, 16'h5A5A, -1);
        repeat (40) send_bit(1'b1);
        send_frame(0, 2'b10, 5'h12, 5'd7, 16'h0, -1);
        check_word("R7", "word 7 after blanked start", cap, 16'h0000);
        cur_req = "R8";
        send_frame(0, 2'b10, 5'h12, 5'd3, 16'h0, -1);
        check_word("R8", "word 3 cleared by reset", cap, 16'h0000);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule